// File: doc/BRIEF.md
# Multiplier-free cubic waveform evaluator

This block produces one channel of a piecewise-cubic waveform without a single multiplier. Each piece, or knot, is given as four starting values for a chain of four 48-bit accumulators (orders 0 to 3), plus a step count and a time-scale exponent. On every evolution step each accumulator adds in the value that the next-higher accumulator held before the step. The cubic term therefore turns into a running sum of running sums. The output sample is the upper 16 bits of the order-0 accumulator. The coefficients are converted into starting values elsewhere, before they reach the block.

A knot is written as a stream of 16-bit words. `ld_begin` clears the assembly buffer. Each `ld_word_vld` appends one word. `ld_start` commits the assembled words, together with `ld_dur` and `ld_exp`, into a one-deep staging slot. The staged knot takes over the accumulators at the exact clock where the running knot would have taken its next step. If the running knot has ended and nothing is staged, the block freezes: it stops evolving and holds its sample. `knot_ready` high means the staging slot is free and asks the host for the next knot.

Top module: `spline_eval`

## Requirements
- R1: Word k of a knot is the k-th word appended after `ld_begin`. Order 0 takes word 0. Order 1 takes words 2:1, order 2 takes words 5:3 and order 3 takes words 8:6, the lowest word first in each case. Each coefficient is placed at the most significant end of its 48-bit accumulator, with zeros below it. During a knot's first step period the sample equals word 0.
- R2: `ld_begin` zeroes all nine assembly words. Words that are not appended before `ld_start` load as zero. Appends beyond the ninth word are dropped.
- R3: On each step, accumulator n becomes acc[n] + acc[n+1] for n = 0, 1 and 2, both operands taken from before the step. Accumulator 3 stays constant within a knot. The sample is bits 47:32 of accumulator 0.
- R4: With exponent E (4 bits) and duration T (16 bits, never zero), one step period lasts 2^E clocks and the knot lasts T·2^E clocks, counted from the clock edge that loads it.
- R5: If a knot is staged when the running knot's last step period ends, that knot is loaded at that same edge. The last sample of the old knot is followed directly by word 0 of the new one, with no repeated or skipped sample.
- R6: If the last step period ends with nothing staged, `busy` falls and all accumulators hold, so the sample stays at its last value. A knot committed while the block is idle is loaded at the clock edge after the commit.
- R7: `knot_ready` is low while a knot is staged. An `ld_start` seen while `knot_ready` is low is ignored.
- R8: A synchronous active-high reset clears the accumulators, the step prescaler and the staging slot, so that sample is 0, `busy` is 0 and `knot_ready` is 1.
- R9: There is no saturation. An accumulator that overflows wraps modulo 2^48, so a sample of 0x7FFF stepped by +1 becomes 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_begin | input | 1 | Clear the knot assembly buffer |
| ld_word_vld | input | 1 | Append `ld_word` to the assembly buffer |
| ld_word | input | 16 | Coefficient word, lowest word of each coefficient first |
| ld_start | input | 1 | Commit the assembled knot to the staging slot |
| ld_dur | input | 16 | Step count T of the committed knot |
| ld_exp | input | 4 | Step exponent E of the committed knot |
| sample | output | 16 | Current waveform sample |
| busy | output | 1 | A knot is executing |
| knot_ready | output | 1 | Staging slot is free and the next knot may be committed |

## Verification
The assertions assume that a committed knot never has a zero duration, and that `ld_begin` and `ld_word_vld` are never high in the same cycle. The stimulus keeps to both assumptions: it gives every knot a positive step count and drives the load strobes only one at a time, at clock falling edges. Apart from these, the assertions allow any timing of commits. This includes commits while a knot is already staged, which the stimulus issues on purpose to exercise the rejection path.

// File: rtl/spline_pkg.sv
package spline_pkg;

    localparam int WORD_W   = 16;
    localparam int ACC_W    = 48;
    localparam int N_ORD    = 4;
    localparam int N_WORDS  = 9;
    localparam int SAMPLE_W = 16;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ACC_W-1:0]  acc_t;
    typedef acc_t  [N_ORD-1:0]   acc_vec_t;
    typedef word_t [N_WORDS-1:0] word_vec_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } act_e;

    // number of 16-bit words carried by the coefficient of a given order
    function automatic int coef_words(input int ord);
        return (ord == 0) ? 1 : (ord == 1) ? 2 : 3;
    endfunction

    // index of the first word of that coefficient in the knot word stream
    function automatic int coef_base(input int ord);
        return (ord == 0) ? 0 : (ord == 1) ? 1 : (ord == 2) ? 3 : 6;
    endfunction

    // place each coefficient at the most significant end of its accumulator
    function automatic acc_vec_t words_to_acc(input word_vec_t w);
        acc_vec_t r;
        r = '0;
        for (int o = 0; o < N_ORD; o++) begin
            for (int k = 0; k < coef_words(o); k++) begin
                r[o][(ACC_W - WORD_W*coef_words(o)) + WORD_W*k +: WORD_W] =
                    w[coef_base(o) + k];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/spline_loader.sv
module spline_loader
    import spline_pkg::*;
#(
    parameter int DUR_W = 16,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_begin,
    input  logic             ld_word_vld,
    input  word_t            ld_word,
    input  logic             ld_start,
    input  logic [DUR_W-1:0] ld_dur,
    input  logic [EXP_W-1:0] ld_exp,
    input  logic             take,
    output logic             pending,
    output acc_vec_t         stg_init,
    output logic [DUR_W-1:0] stg_dur,
    output logic [EXP_W-1:0] stg_exp
);
    localparam int IDX_W = $clog2(N_WORDS + 1);

    word_vec_t        asm_words;
    logic [IDX_W-1:0] idx;
    logic             commit;

    assign commit = ld_start && !pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            asm_words <= '0;
            idx       <= '0;
        end else if (ld_begin) begin
            asm_words <= '0;
            idx       <= '0;
        end else if (ld_word_vld && idx < IDX_W'(N_WORDS)) begin
            asm_words[idx] <= ld_word;
            idx            <= idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            stg_init <= '0;
            stg_dur  <= '0;
            stg_exp  <= '0;
        end else begin
            if (take) pending <= 1'b0;
            if (commit) begin
                pending  <= 1'b1;
                stg_init <= words_to_acc(asm_words);
                stg_dur  <= ld_dur;
                stg_exp  <= ld_exp;
            end
        end
    end

    // R7: a commit while the slot is occupied leaves the staged knot untouched
    a_r7_reject_when_full: assert property (@(posedge clk) disable iff (rst)
        (ld_start && pending && !take) |=> $stable(stg_init) && $stable(stg_dur) && pending);

    // R2: begin restarts the append position
    a_r2_begin_rewinds: assert property (@(posedge clk) disable iff (rst)
        ld_begin |=> (idx == '0));

    // R4: input assumption, a committed knot has a nonzero step count
    a_r4_dur_nonzero: assert property (@(posedge clk) disable iff (rst)
        commit |-> (ld_dur != '0));

    // R2: input assumption, begin and append never coincide
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(ld_begin && ld_word_vld));

endmodule

// File: rtl/spline_pacer.sv
module spline_pacer
    import spline_pkg::*;
#(
    parameter int DUR_W = 16,
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pending,
    input  logic [DUR_W-1:0] stg_dur,
    input  logic [EXP_W-1:0] stg_exp,
    output act_e             act,
    output logic             busy
);
    localparam int PRE_W = (1 << EXP_W) - 1;

    logic [DUR_W-1:0] left;
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;
    logic [EXP_W-1:0] cur_exp;
    logic             tick;
    logic             last;

    assign mask = (PRE_W'(1) << cur_exp) - PRE_W'(1);
    assign tick = busy && (pre == mask);
    assign last = (left == DUR_W'(1));

    always_comb begin
        if (pending && (!busy || (tick && last)))
            act = ACT_LOAD;
        else if (tick && !last)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            left    <= '0;
            pre     <= '0;
            cur_exp <= '0;
        end else if (act == ACT_LOAD) begin
            busy    <= 1'b1;
            left    <= stg_dur;
            cur_exp <= stg_exp;
            pre     <= '0;
        end else if (busy) begin
            if (tick) begin
                pre <= '0;
                if (last) busy <= 1'b0;
                else      left <= left - DUR_W'(1);
            end else begin
                pre <= pre + PRE_W'(1);
            end
        end
    end

    // R4: the prescaler never runs past the step period of the running knot
    a_r4_pre_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pre <= mask));

    // R4: a running knot always has at least one step period left
    a_r4_left_live: assert property (@(posedge clk) disable iff (rst)
        busy |-> (left != '0));

    // R6: no evolution while idle
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (act != ACT_STEP));

    // R6: ending with nothing staged drops busy on the next cycle
    a_r6_end_drops_busy: assert property (@(posedge clk) disable iff (rst)
        (tick && last && !pending) |=> !busy);

endmodule

// File: rtl/spline_accum.sv
module spline_accum
    import spline_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  act_e     act,
    input  acc_vec_t init,
    output acc_vec_t acc
);
    for (genvar n = 0; n < N_ORD; n++) begin : g_ord
        if (n == N_ORD - 1) begin : g_top
            always_ff @(posedge clk) begin
                if (rst)                  acc[n] <= '0;
                else if (act == ACT_LOAD) acc[n] <= init[n];
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst)                  acc[n] <= '0;
                else if (act == ACT_LOAD) acc[n] <= init[n];
                else if (act == ACT_STEP) acc[n] <= acc[n] + acc[n+1];
            end
        end
    end

    // R3: the highest order term is constant inside a knot
    a_r3_top_constant: assert property (@(posedge clk) disable iff (rst)
        (act != ACT_LOAD) |=> $stable(acc[N_ORD-1]));

    // R9: order-0 sum wraps modulo 2^48 across a step
    a_r9_wrap_sum: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_STEP) |=> (acc[0] == ACC_W'($past(acc[0]) + $past(acc[1]))));

    // R1: a freshly loaded order-0 term has zero fraction bits
    a_r1_load_clean: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOAD) |=> (acc[0][ACC_W-SAMPLE_W-1:0] == '0));

endmodule

// File: rtl/spline_eval.sv
module spline_eval
    import spline_pkg::*;
#(
    parameter int DUR_W = 16,
    parameter int EXP_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_begin,
    input  logic                ld_word_vld,
    input  logic [WORD_W-1:0]   ld_word,
    input  logic                ld_start,
    input  logic [DUR_W-1:0]    ld_dur,
    input  logic [EXP_W-1:0]    ld_exp,
    output logic [SAMPLE_W-1:0] sample,
    output logic                busy,
    output logic                knot_ready
);
    logic             pending;
    acc_vec_t         stg_init;
    logic [DUR_W-1:0] stg_dur;
    logic [EXP_W-1:0] stg_exp;
    act_e             act;
    acc_vec_t         acc;

    spline_loader #(.DUR_W(DUR_W), .EXP_W(EXP_W)) u_loader (
        .clk        (clk),
        .rst        (rst),
        .ld_begin   (ld_begin),
        .ld_word_vld(ld_word_vld),
        .ld_word    (ld_word),
        .ld_start   (ld_start),
        .ld_dur     (ld_dur),
        .ld_exp     (ld_exp),
        .take       (act == ACT_LOAD),
        .pending    (pending),
        .stg_init   (stg_init),
        .stg_dur    (stg_dur),
        .stg_exp    (stg_exp)
    );

    spline_pacer #(.DUR_W(DUR_W), .EXP_W(EXP_W)) u_pacer (
        .clk    (clk),
        .rst    (rst),
        .pending(pending),
        .stg_dur(stg_dur),
        .stg_exp(stg_exp),
        .act    (act),
        .busy   (busy)
    );

    spline_accum u_accum (
        .clk (clk),
        .rst (rst),
        .act (act),
        .init(stg_init),
        .acc (acc)
    );

    assign sample     = acc[0][ACC_W-1 -: SAMPLE_W];
    assign knot_ready = !pending;

    // R6: idle with an empty slot means the sample is frozen
    a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
        (!busy && knot_ready) |=> $stable(sample));

    // R5: busy never drops while a knot waits in the slot
    a_r5_no_gap: assert property (@(posedge clk) disable iff (rst)
        (busy && !knot_ready) |=> busy);

endmodule

// File: tb/spline_eval_bench.sv
`timescale 1ns/1ps
module spline_eval_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_begin = 1'b0;
    logic        ld_word_vld = 1'b0;
    logic [15:0] ld_word = '0;
    logic        ld_start = 1'b0;
    logic [15:0] ld_dur = '0;
    logic [3:0]  ld_exp = '0;
    logic [15:0] sample;
    logic        busy;
    logic        knot_ready;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spline_eval u_spline_eval (
        .clk(clk), .rst(rst), .ld_begin(ld_begin), .ld_word_vld(ld_word_vld),
        .ld_word(ld_word), .ld_start(ld_start), .ld_dur(ld_dur), .ld_exp(ld_exp),
        .sample(sample), .busy(busy), .knot_ready(knot_ready)
    );

    // ---------------- behavioural reference model ----------------
    logic [47:0] m_acc [4];
    logic [15:0] m_words [9];
    logic [15:0] s_words [9];
    int          m_idx;
    logic        m_pend, m_busy, p0;
    int          m_dur, m_exp, m_cnt, m_steps, s_dur, s_exp;

    task automatic m_load();
        m_acc[0] = {s_words[0], 32'h0};
        m_acc[1] = {s_words[2], s_words[1], 16'h0};
        m_acc[2] = {s_words[5], s_words[4], s_words[3]};
        m_acc[3] = {s_words[8], s_words[7], s_words[6]};
        m_dur = s_dur; m_exp = s_exp;
        m_cnt = 0; m_steps = 0; m_busy = 1'b1; m_pend = 1'b0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) m_acc[i] = '0;
            for (int i = 0; i < 9; i++) begin m_words[i] = '0; s_words[i] = '0; end
            m_idx = 0; m_pend = 1'b0; m_busy = 1'b0;
            m_cnt = 0; m_steps = 0; m_dur = 0; m_exp = 0; s_dur = 0; s_exp = 0;
        end else begin
            p0 = m_pend;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == (1 << m_exp)) begin
                    m_cnt = 0;
                    m_steps++;
                    if (m_steps == m_dur) begin
                        if (p0) m_load(); else m_busy = 1'b0;
                    end else begin
                        m_acc[0] = m_acc[0] + m_acc[1];
                        m_acc[1] = m_acc[1] + m_acc[2];
                        m_acc[2] = m_acc[2] + m_acc[3];
                    end
                end
            end else if (p0) begin
                m_load();
            end
            if (ld_start && !p0) begin
                for (int i = 0; i < 9; i++) s_words[i] = m_words[i];
                s_dur = ld_dur; s_exp = ld_exp; m_pend = 1'b1;
            end
            if (ld_begin) begin
                for (int i = 0; i < 9; i++) m_words[i] = '0;
                m_idx = 0;
            end else if (ld_word_vld && m_idx < 9) begin
                m_words[m_idx] = ld_word;
                m_idx++;
            end
        end
    end

    // R3 R4 R5 R6 R7: full-output comparison against the model every cycle
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (sample !== m_acc[0][47:32] || busy !== m_busy || knot_ready !== !m_pend) begin
                errors++;
                $display("FAIL R3 model: sample=%h busy=%b ready=%b expected sample=%h busy=%b ready=%b",
                         sample, busy, knot_ready, m_acc[0][47:32], m_busy, !m_pend);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [15:0] kw [9];

    task automatic clear_kw();
        for (int i = 0; i < 9; i++) kw[i] = '0;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_knot(input int nw, input logic [15:0] dur, input logic [3:0] ex);
        ld_begin = 1'b1;
        @(negedge clk);
        ld_begin = 1'b0;
        for (int i = 0; i < nw; i++) begin
            ld_word_vld = 1'b1; ld_word = kw[i];
            @(negedge clk);
        end
        ld_word_vld = 1'b0;
        ld_start = 1'b1; ld_dur = dur; ld_exp = ex;
        @(negedge clk);
        ld_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && (busy || !knot_ready); i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        clear_kw();
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 sample", sample, 16'h0000);
        chk("R8 busy", {15'h0, busy}, 16'h0000);
        chk("R8 ready", {15'h0, knot_ready}, 16'h0001);
        rst = 1'b0;
        @(negedge clk);

        // R1 R3 R6: linear ramp, then freeze
        clear_kw(); kw[0] = 16'h1000; kw[2] = 16'h0001;
        load_knot(3, 16'd4, 4'd0);
        @(negedge clk); chk("R1 first sample", sample, 16'h1000);
        @(negedge clk); chk("R3 ramp 1", sample, 16'h1001);
        @(negedge clk); @(negedge clk); chk("R3 ramp 3", sample, 16'h1003);
        @(negedge clk); chk("R6 busy low", {15'h0, busy}, 16'h0000);
        repeat (3) @(negedge clk); chk("R6 frozen", sample, 16'h1003);
        wait_idle();

        // R3: quadratic term
        clear_kw(); kw[5] = 16'h0001;
        load_knot(6, 16'd4, 4'd0);
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk("R3 quad 2", sample, 16'h0001);
        @(negedge clk); chk("R3 quad 3", sample, 16'h0003);
        wait_idle();

        // R1 R3: cubic term through all nine words
        clear_kw(); kw[8] = 16'h0001;
        load_knot(9, 16'd6, 4'd0);
        repeat (6) @(negedge clk);
        chk("R3 cubic 5", sample, 16'h000A);
        wait_idle();

        // R2: unwritten words load as zero after begin
        clear_kw(); kw[0] = 16'h2222;
        load_knot(1, 16'd3, 4'd0);
        repeat (3) @(negedge clk);
        chk("R2 constant", sample, 16'h2222);
        wait_idle();

        // R9: wrap without saturation
        clear_kw(); kw[0] = 16'h7FFF; kw[2] = 16'h0001;
        load_knot(3, 16'd2, 4'd0);
        @(negedge clk); chk("R9 before", sample, 16'h7FFF);
        @(negedge clk); chk("R9 wrapped", sample, 16'h8000);
        wait_idle();

        // R4: exponent 2, two steps -> 8 busy clocks
        clear_kw(); kw[0] = 16'h3000; kw[2] = 16'h0001;
        load_knot(3, 16'd2, 4'd2);
        begin
            int n;
            n = 0;
            @(negedge clk);
            while (busy && n < 100) begin
                n++;
                if (n == 4) chk("R4 hold 4 clocks", sample, 16'h3000);
                if (n == 5) chk("R4 step after 4", sample, 16'h3001);
                @(negedge clk);
            end
            chk("R4 knot length", 16'(n), 16'd8);
        end
        wait_idle();

        // R5 R7: back-to-back knots, slot full flag
        clear_kw(); kw[0] = 16'h4000; kw[2] = 16'h0001;
        load_knot(3, 16'd6, 4'd0);
        @(negedge clk); chk("R5 A start", sample, 16'h4000);
        clear_kw(); kw[0] = 16'h5000;
        load_knot(1, 16'd4, 4'd0);
        chk("R7 ready low", {15'h0, knot_ready}, 16'h0000);
        @(negedge clk); @(negedge clk); chk("R5 A last", sample, 16'h4005);
        @(negedge clk); chk("R5 B first", sample, 16'h5000);
        wait_idle();

        // R7: commit while slot full is ignored
        clear_kw(); kw[0] = 16'h6000;
        load_knot(1, 16'd30, 4'd0);
        clear_kw(); kw[0] = 16'h7000;
        load_knot(1, 16'd2, 4'd0);
        clear_kw(); kw[0] = 16'h7777;
        load_knot(1, 16'd2, 4'd0);
        wait_idle();
        chk("R7 ignored commit", sample, 16'h7000);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule